// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service Sequence

This block is a watchdog peripheral seen by software as four 16-bit registers on a small register bus. Once enabled it counts down in half-second steps, where one step is a fixed number of pulses on a slow tick-enable input. Software keeps it alive by writing a two-word key pair to the service register. If the count runs out, the block either pulses the system reset output or drives the active-low watchdog line low, as the control register selects. A reset caused this way is recorded in a cause register that only a power-on reset clears.

The block also offers a software-requested system reset, which is taken on the next slow tick. It has an optional pause of the count while a low-power indicator is high. A boot-time counter, started by every reset, pulses the watchdog line once unless software disarms it first.

Register byte offsets: 0x0 control, 0x2 service, 0x4 reset cause, 0x8 boot counter. Control fields: bits 15:8 timeout value n, bit 4 software-reset request (active low), bit 3 expiry route, bit 2 enable, bit 0 low-power pause.

Top module: `wdt_timer`

## Requirements
- R1: After reset, control reads 0x0010, the boot-counter register reads 0x0001 and the system reset output is low. After power-on reset, the cause register reads 0x0000.
- R2: A service write of 0x5555 followed by a service write of 0xAAAA reloads the counter with the timeout value and restarts the half-second step from zero.
- R3: A service write other than 0xAAAA after 0x5555 returns the key detector to idle without a reload. A write of 0xAAAA while idle does not reload.
- R4: With timeout value n, expiry occurs on the TICKS_PER_HALF*(n+1)-th tick-enable pulse after a reload.
- R5: The enable bit (control bit 2) cannot be cleared by software once set, and the timer keeps running.
- R6: The low-power pause bit (control bit 0) takes its value from the first control write after reset only. While it is 1 and lp_mode is high, tick pulses do not advance the count.
- R7: A new timeout value written while running takes effect from the next reload, including the automatic reload at expiry.
- R8: On expiry with control bit 3 at 0, sys_rst_out is high for exactly PULSE_CYCLES clocks. With bit 3 at 1, wdog_line_n is low for PULSE_CYCLES clocks instead and sys_rst_out stays low.
- R9: The cause register sets bit 1 on a timeout-caused system reset pulse and bit 0 on a software-requested one. It keeps its value through rst_n and is cleared only by por_n.
- R10: A control write with bit 4 at 0 requests a system reset. Control bit 4 reads 0 while the request is pending, and sys_rst_out rises on the clock after the next tick-enable pulse.
- R11: After reset the boot counter asserts wdog_line_n low for exactly one clock on the PD_TICKS-th tick pulse, after which the boot-counter register reads 0.
- R12: Writing the boot-counter register with bit 0 at 0 before it expires cancels the pulse. Writing bit 0 as 1 afterwards does not re-arm it.
- R13: While the enable bit has not been set since reset, no expiry occurs however many tick pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low system reset for all state except the cause register |
| por_n | input | 1 | Active-low power-on reset; also clears the cause register |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe for one clock |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tick_en | input | 1 | One-clock pulse per slow-clock period |
| lp_mode | input | 1 | Low-power indicator |
| sys_rst_out | output | 1 | System reset request pulse, active high |
| wdog_line_n | output | 1 | Active-low watchdog line |

## Verification
Properties check on every cycle that the enable bit never falls, that the pause bit is frozen after the first control write, and that the count holds during a low-power pause. They also check that a pending software request turns into a reset pulse right after a tick, that the boot pulse lasts one clock, that a correct key pair reloads the count, and that a stray key disarms the detector. The exact number of ticks to expiry, the deferred effect of a new timeout value, the choice between the two outputs, the cause record surviving a system reset, and cancelling the boot pulse are shown only by the bench's directed and random scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int          ADDR_W   = 4;
    localparam logic [3:0]  A_CTRL   = 4'h0;
    localparam logic [3:0]  A_SVC    = 4'h2;
    localparam logic [3:0]  A_CAUSE  = 4'h4;
    localparam logic [3:0]  A_BOOT   = 4'h8;
    localparam logic [15:0] KEY_ARM  = 16'h5555;
    localparam logic [15:0] KEY_FIRE = 16'hAAAA;
    localparam int          B_PAUSE  = 0;
    localparam int          B_EN     = 2;
    localparam int          B_ROUTE  = 3;
    localparam int          B_SWRQ_N = 4;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ARMED
    } seq_e;
endpackage

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        reload
);
    seq_e st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (svc_wr) begin
            if (st_q == SEQ_ARMED && svc_data == KEY_FIRE) begin
                reload = 1'b1;
                st_d   = SEQ_IDLE;
            end else if (svc_data == KEY_ARM) begin
                st_d = SEQ_ARMED;
            end else begin
                st_d = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // R3: any key other than the arming word leaves the detector idle
    p_stray_key_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_data != KEY_ARM) |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic step
);
    localparam int          W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        step  = !clr && adv && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = '0;
        else if (adv)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int          W    = $clog2(LEN + 1);
    localparam logic [W-1:0] LOAD = W'(LEN);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
        else                  cnt_d = '0;
        active = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: a kick is always followed by an active output
    p_kick_starts_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int TICKS_PER_HALF = 16384,
    parameter int PD_TICKS       = 524288,
    parameter int PULSE_CYCLES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic               tick_en,
    input  logic               lp_mode,
    output logic               sys_rst_out,
    output logic               wdog_line_n
);
    localparam int            PDW     = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
    localparam logic [PDW-1:0] PD_LAST = PDW'(PD_TICKS - 1);

    typedef struct packed {
        logic [7:0]     tmo;
        logic           route;
        logic           en;
        logic           pause;
        logic           pause_lock;
        logic           sreq;
        logic [7:0]     cnt;
        logic           pd_en;
        logic [PDW-1:0] pd_cnt;
        logic           pd_pulse;
    } st_t;

    st_t d, q;
    logic [1:0] cause_d, cause_q;

    logic wr_ctrl, wr_svc, wr_boot;
    logic svc_reload, start_load, load_cnt;
    logic run, half_step, expire, fire_sw;
    logic [1:0] kick, act;

    assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
    assign wr_svc     = bus_we && (bus_addr == A_SVC);
    assign wr_boot    = bus_we && (bus_addr == A_BOOT);
    assign start_load = wr_ctrl && bus_wdata[B_EN] && !q.en;
    assign load_cnt   = svc_reload || start_load;
    assign run        = q.en && !(q.pause && lp_mode);

    wdt_svc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (wr_svc),
        .svc_data (bus_wdata),
        .reload   (svc_reload)
    );

    wdt_prescale #(.DIV(TICKS_PER_HALF)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_cnt),
        .adv   (run && tick_en),
        .step  (half_step)
    );

    always_comb begin
        d          = q;
        d.pd_pulse = 1'b0;
        fire_sw    = 1'b0;
        expire     = 1'b0;
        if (q.sreq && tick_en) begin
            fire_sw = 1'b1;
            d.sreq  = 1'b0;
        end
        if (wr_ctrl) begin
            d.tmo        = bus_wdata[15:8];
            d.route      = bus_wdata[B_ROUTE];
            d.en         = q.en | bus_wdata[B_EN];
            d.pause_lock = 1'b1;
            if (!q.pause_lock)      d.pause = bus_wdata[B_PAUSE];
            if (!bus_wdata[B_SWRQ_N]) d.sreq = 1'b1;
        end
        if (load_cnt) begin
            d.cnt = d.tmo;
        end else if (half_step) begin
            if (q.cnt == 8'd0) begin
                expire = 1'b1;
                d.cnt  = q.tmo;
            end else begin
                d.cnt = q.cnt - 8'd1;
            end
        end
        if (q.pd_en && tick_en) begin
            if (q.pd_cnt == PD_LAST) begin
                d.pd_en    = 1'b0;
                d.pd_pulse = 1'b1;
            end else begin
                d.pd_cnt = q.pd_cnt + PDW'(1);
            end
        end
        if (wr_boot && !bus_wdata[0]) begin
            d.pd_en    = 1'b0;
            d.pd_pulse = 1'b0;
        end
    end

    assign kick[0] = fire_sw || (expire && !q.route);
    assign kick[1] = expire && q.route;

    always_comb begin
        cause_d = cause_q;
        if (kick[0]) cause_d = {expire && !q.route, fire_sw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.pd_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 2'b00;
        else        cause_q <= cause_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_out
        wdt_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (kick[g]),
            .active (act[g])
        );
    end

    assign sys_rst_out = act[0];
    assign wdog_line_n = !(act[1] || q.pd_pulse);

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {q.tmo, 3'b000, !q.sreq, q.route, q.en, 1'b0, q.pause};
            A_CAUSE: bus_rdata = {14'd0, cause_q};
            A_BOOT:  bus_rdata = {15'd0, q.pd_en};
            default: bus_rdata = 16'd0;
        endcase
    end

    // R2: a completed key pair loads the programmed timeout
    p_key_pair_reloads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_reload |=> (q.cnt == $past(q.tmo)));
    // R5: enable never falls while out of reset
    p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.en |=> q.en);
    // R6: pause bit frozen after the first control write
    p_pause_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.pause_lock |=> $stable(q.pause));
    // R6: count holds during a low-power pause
    p_lp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pause && lp_mode && !load_cnt) |=> $stable(q.cnt));
    // R10: a pending software request is taken on the next tick
    p_swreq_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sreq && tick_en) |=> sys_rst_out);
    // R11: the boot pulse lasts a single clock
    p_boot_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.pd_pulse |=> !q.pd_pulse);
    // R13: a reset pulse needs an enabled timer or a software request
    p_rst_has_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_out) |-> ($past(q.en) || $past(q.sreq)));
endmodule

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
    localparam int DIV = 2;
    localparam int PD  = 6;
    localparam int PC  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        lp_mode = 1'b0;
    logic        sys_rst_out;
    logic        wdog_line_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdt_timer #(.TICKS_PER_HALF(DIV), .PD_TICKS(PD), .PULSE_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .lp_mode(lp_mode), .sys_rst_out(sys_rst_out),
        .wdog_line_n(wdog_line_n)
    );

    function automatic int exp_ticks(input int n);
        return DIV * (n + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit por);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; lp_mode = 1'b0; bus_we = 1'b0;
        if (por) por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic service();
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
    endtask

    // ticks with no activity expected on either output
    task automatic ticks_quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (sys_rst_out || !wdog_line_n) seen = 1'b1;
        end
        chk(tag, seen, 1'b0);
    endtask

    task automatic chk_rst_pulse(input string tag);
        for (int i = 0; i < PC; i++) begin
            chk(tag, {sys_rst_out, wdog_line_n}, 2'b11);
            @(negedge clk);
        end
        chk(tag, sys_rst_out, 1'b0);
    endtask

    task automatic chk_line_pulse(input string tag);
        for (int i = 0; i < PC; i++) begin
            chk(tag, {sys_rst_out, wdog_line_n}, 2'b00);
            @(negedge clk);
        end
        chk(tag, wdog_line_n, 1'b1);
    endtask

    initial begin
        logic [15:0] v;
        int n, k, rem, seed;
        seed = $urandom(32'h5EED1234);

        do_reset(1'b1);
        rd(4'h0, v); chk("R1 ctrl reset", v, 16'h0010);
        rd(4'h4, v); chk("R1 cause after power-on", v, 16'h0000);
        rd(4'h8, v); chk("R1 boot reg reset", v, 16'h0001);
        chk("R1 outputs idle", {sys_rst_out, wdog_line_n}, 2'b01);

        // R11 boot counter pulse
        ticks_quiet(PD - 1, "R11 before boot expiry");
        tick();
        chk("R11 boot pulse low", wdog_line_n, 1'b0);
        @(negedge clk);
        chk("R11 boot pulse one clock", wdog_line_n, 1'b1);
        rd(4'h8, v); chk("R11 boot reg after pulse", v, 16'h0000);

        // R13 disabled timer never expires
        ticks_quiet(20, "R13 disabled no expiry");

        // R12 disarm boot counter
        do_reset(1'b0);
        ticks_quiet(2, "R12 early ticks");
        wr(4'h8, 16'h0000);
        wr(4'h8, 16'h0001);
        rd(4'h8, v); chk("R12 no re-arm", v, 16'h0000);
        ticks_quiet(10, "R12 no boot pulse");

        // R4 basic expiry, n=3
        wr(4'h0, 16'h0315);
        rd(4'h0, v); chk("R6 ctrl first write", v, 16'h0315);
        ticks_quiet(exp_ticks(3) - 1, "R4 before expiry");
        tick();
        chk_rst_pulse("R8 reset pulse");
        rd(4'h4, v); chk("R9 cause timeout", v, 16'h0002);

        // R2 service reload
        service();
        ticks_quiet(5, "R2 partial");
        service();
        ticks_quiet(exp_ticks(3) - 1, "R2 reload delays expiry");
        tick();
        chk("R2 expiry after reload", sys_rst_out, 1'b1);
        chk_rst_pulse("R2 pulse");

        // R3 broken key sequence
        service();
        ticks_quiet(5, "R3 partial");
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        ticks_quiet(2, "R3 no reload yet");
        tick();
        chk("R3 expiry on original schedule", sys_rst_out, 1'b1);
        chk_rst_pulse("R3 pulse");

        // R7 new timeout applies at next reload
        service();
        wr(4'h0, 16'h0115);
        ticks_quiet(exp_ticks(3) - 1, "R7 old timeout still used");
        tick();
        chk("R7 expiry old value", sys_rst_out, 1'b1);
        chk_rst_pulse("R7 pulse");
        ticks_quiet(exp_ticks(1) - 1, "R7 new timeout after reload");
        tick();
        chk("R7 expiry new value", sys_rst_out, 1'b1);
        chk_rst_pulse("R7 pulse2");

        // R5 enable sticky, R6 pause write-once
        wr(4'h0, 16'h0110);
        rd(4'h0, v); chk("R5 R6 enable and pause kept", v, 16'h0115);
        ticks_quiet(exp_ticks(1) - 1, "R5 still counting");
        tick();
        chk("R5 expiry after clear attempt", sys_rst_out, 1'b1);
        chk_rst_pulse("R5 pulse");

        // R6 low-power pause
        service();
        tick();
        lp_mode = 1'b1;
        ticks_quiet(10, "R6 paused");
        lp_mode = 1'b0;
        ticks_quiet(2, "R6 resumed");
        tick();
        chk("R6 expiry after pause", sys_rst_out, 1'b1);
        chk_rst_pulse("R6 pulse");

        // R9 survives rst_n; R8 line route
        do_reset(1'b0);
        rd(4'h4, v); chk("R9 cause survives rst_n", v, 16'h0002);
        wr(4'h8, 16'h0000);
        wr(4'h0, 16'h001C);
        rd(4'h0, v); chk("R8 ctrl route", v, 16'h001C);
        ticks_quiet(exp_ticks(0) - 1, "R8 before line expiry");
        tick();
        chk_line_pulse("R8 line pulse");

        // R10 software reset
        service();
        wr(4'h0, 16'h000C);
        rd(4'h0, v); chk("R10 request pending", v, 16'h000C);
        repeat (5) @(negedge clk);
        chk("R10 waits for tick", sys_rst_out, 1'b0);
        tick();
        chk_rst_pulse("R10 sw pulse");
        rd(4'h4, v); chk("R9 R10 cause software", v, 16'h0001);
        rd(4'h0, v); chk("R10 request cleared", v, 16'h001C);

        // R9 cleared by power-on
        do_reset(1'b1);
        rd(4'h4, v); chk("R9 cleared by por", v, 16'h0000);
        rd(4'h0, v); chk("R1 ctrl after por", v, 16'h0010);

        // random timeouts and service patterns (R2 R3 R4)
        for (int it = 0; it < 8; it++) begin
            do_reset(1'b0);
            wr(4'h8, 16'h0000);
            n = $urandom % 5;
            wr(4'h0, {n[7:0], 8'h15});
            k = $urandom % exp_ticks(n);
            ticks_quiet(k, "R4 random lead");
            if ($urandom % 2 == 1) begin
                wr(4'h2, 16'h5555);
                wr(4'h2, 16'h0F00 | 16'($urandom % 256));
                rem = exp_ticks(n) - k;
            end else begin
                service();
                rem = exp_ticks(n);
            end
            ticks_quiet(rem - 1, "R4 random wait");
            tick();
            chk("R4 random expiry", sys_rst_out, 1'b1);
            chk_rst_pulse("R8 random pulse");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule